// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter with Source Select

This block is the general-purpose timer of a small microcontroller. It has an 8-bit up-counter that raises a sticky overflow flag when it wraps from all-ones to zero. The count source is either a one-cycle tick from the internal instruction clock or edges on an external counter pin. A configuration bit selects between the two sources.

The external pin is asynchronous. It passes a two-flop synchronizer into the core clock domain, and a configuration bit then picks whether rising or falling transitions count. An optional prescaler can sit ahead of the counter. A 3-bit select chooses one of eight taps, giving division by 2, 4, 8 and so on up to 256. Software can load the counter over a simple write strobe and read it back at any time. Loading the counter also restarts the prescaler. A separate enable bit masks the overflow flag onto the interrupt output.

Top module: `tmr8_prescaled`

## Requirements
- R1: While `rst_n` is low, `cnt_q` is 0, `ovf_flag` is 0 and `irq` is 0.
- R2: With `cfg_src`=0 (internal) and `cfg_pre_en`=0, each clock cycle with `tick_int`=1 adds one to `cnt_q` at that clock edge.
- R3: With `cfg_src`=1 (external) and `cfg_edge`=0, a low-to-high change of `ext_pin` adds one to `cnt_q` on the third rising clock edge after the change, not earlier. A high-to-low change adds nothing.
- R4: With `cfg_src`=1 and `cfg_edge`=1, a high-to-low change of `ext_pin` adds one, and a low-to-high change adds nothing.
- R5: With `cfg_src`=0, activity on `ext_pin` does not change `cnt_q`. With `cfg_src`=1, `tick_int` does not change `cnt_q`.
- R6: With `cfg_pre_en`=1 and select value n on `cfg_pre_sel`, `cnt_q` advances once per 2^(n+1) source events.
- R7: A cycle with `bus_wr`=1 loads `bus_wdata` into `cnt_q` at that edge. The load takes priority over a simultaneous increment and empties the prescaler, so the next increment comes after a full 2^(n+1) events.
- R8: An increment from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until a cycle with `flag_clr`=1. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when `ovf_flag`=1 and `cfg_irq_en`=1.
- R10: Changing `cfg_src` or `cfg_edge` while `ext_pin` holds a steady level, and with no internal tick, leaves `cnt_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | One-cycle internal instruction-clock tick |
| ext_pin | input | 1 | Asynchronous external counter input |
| cfg_src | input | 1 | Source select: 0 internal tick, 1 external pin |
| cfg_edge | input | 1 | External edge select: 0 rising, 1 falling |
| cfg_pre_en | input | 1 | 1 routes events through the prescaler |
| cfg_pre_sel | input | 3 | Prescaler tap n, ratio 2^(n+1) |
| cfg_irq_en | input | 1 | Interrupt output enable |
| bus_wr | input | 1 | Counter write strobe |
| bus_wdata | input | 8 | Counter write value |
| flag_clr | input | 1 | Clears the overflow flag |
| cnt_q | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The hardest case to reach from the ports is a correct overflow after a long run of prescaled events that start from an arbitrary loaded value. The stimulus loads a random start value, picks a random tap and bypass setting, and issues hundreds of ticks. The expected count and flag come from the event total divided by the ratio. Directed cases cover the other hard spots:
- the exact three-edge latency of the synchronized pin,
- a write and a tick that land in the same cycle,
- a wrap and a flag clear that land in the same cycle.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_sel,
  output logic evt
);
  import tmr8_pkg::*;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              hist_q, hist_d;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    hist_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  // Edge is judged only from sampled history, so a select change alone never fires
  always_comb begin
    if (edge_e'(edge_sel) == EDGE_FALL) evt = hist_q & ~lvl;
    else                                evt = ~hist_q & lvl;
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int TAPS  = 8,
  localparam int SEL_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [SEL_W-1:0] sel,
  output logic             evt_out
);
  logic [TAPS-1:0] div_q, div_d;
  logic [TAPS-1:0] tap;
  logic            div_ce;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap[i] = &div_q[i:0];
  end

  always_comb begin
    div_ce = clr | evt_in;
    div_d  = clr ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_ce) div_q <= div_d;
  end

  assign evt_out = pre_en ? (evt_in & tap[sel] & ~clr) : evt_in;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_q,
  output logic         flag_q
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce, flag_d, wrap;

  always_comb begin
    wrap   = inc & ~load & (&cnt_q);
    cnt_ce = load | inc;
    cnt_d  = load ? load_val : cnt_q + 1'b1;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/tmr8_prescaled.sv
module tmr8_prescaled #(
  parameter int CNT_W       = 8,
  parameter int PRE_TAPS    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(PRE_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_int,
  input  logic             ext_pin,
  input  logic             cfg_src,
  input  logic             cfg_edge,
  input  logic             cfg_pre_en,
  input  logic [SEL_W-1:0] cfg_pre_sel,
  input  logic             cfg_irq_en,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag,
  output logic             irq
);
  import tmr8_pkg::*;

  logic ext_evt, src_evt, cnt_inc;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .edge_sel(cfg_edge), .evt(ext_evt)
  );

  assign src_evt = (src_e'(cfg_src) == SRC_EXT) ? ext_evt : tick_int;

  tmr_prescale #(.TAPS(PRE_TAPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .evt_in(src_evt), .clr(bus_wr),
    .pre_en(cfg_pre_en), .sel(cfg_pre_sel), .evt_out(cnt_inc)
  );

  tmr_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .load(bus_wr),
    .load_val(bus_wdata), .flag_clr(flag_clr), .cnt_q(cnt_q), .flag_q(ovf_flag)
  );

  assign irq = ovf_flag & cfg_irq_en;
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_src,
  input logic         tick_int,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic         flag_clr,
  input logic         cfg_irq_en,
  input logic [W-1:0] cnt_q,
  input logic         ovf_flag,
  input logic         irq
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] FULL = '1;

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> cnt_q == $past(bus_wdata));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));

  // R5
  int_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_src && !tick_int && !bus_wr) |=> $stable(cnt_q));

  // R8
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && $past(cnt_q) == FULL && !$past(bus_wr)) |-> ovf_flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (cnt_q == '0 && $past(cnt_q) == FULL));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

bind tmr8_prescaled tmr8_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .tick_int(tick_int),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .flag_clr(flag_clr),
  .cfg_irq_en(cfg_irq_en), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/sim_tmr8_prescaled.sv
module sim_tmr8_prescaled;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_int, ext_pin, cfg_src, cfg_edge, cfg_pre_en, cfg_irq_en;
  logic [2:0] cfg_pre_sel;
  logic       bus_wr, flag_clr;
  logic [7:0] bus_wdata;
  logic [7:0] cnt_q;
  logic       ovf_flag, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tmr8_prescaled u0 (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .ext_pin(ext_pin),
    .cfg_src(cfg_src), .cfg_edge(cfg_edge), .cfg_pre_en(cfg_pre_en),
    .cfg_pre_sel(cfg_pre_sel), .cfg_irq_en(cfg_irq_en), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .flag_clr(flag_clr), .cnt_q(cnt_q),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      tick_int = 1'b1; cyc(1);
      tick_int = 1'b0; cyc(1);
    end
  endtask

  task automatic wr(logic [7:0] v);
    bus_wdata = v; bus_wr = 1'b1; cyc(1);
    bus_wr = 1'b0;
  endtask

  task automatic pin(logic v);
    ext_pin = v; cyc(4);
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; cyc(1);
    flag_clr = 1'b0;
  endtask

  function automatic int exp_incs(int events, bit pre, int sel);
    return pre ? (events >> (sel + 1)) : events;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; tick_int = 0; ext_pin = 0; cfg_src = 0; cfg_edge = 0;
    cfg_pre_en = 0; cfg_pre_sel = 0; cfg_irq_en = 0; bus_wr = 0;
    flag_clr = 0; bus_wdata = 0;
    cyc(3);
    chk("R1 cnt", cnt_q, 0); chk("R1 flag", ovf_flag, 0); chk("R1 irq", irq, 0);
    rst_n = 1'b1; cyc(2);

    // R2 internal counting
    tick(5);
    chk("R2 five ticks", cnt_q, 5);
    tick_int = 1'b1; cyc(3); tick_int = 1'b0; cyc(1);
    chk("R2 held tick", cnt_q, 8);

    // R5 pin ignored with internal source
    pin(1); pin(0); pin(1); pin(0);
    chk("R5 pin ignored", cnt_q, 8);

    // R3 rising edges, latency three edges
    cfg_src = 1'b1; cyc(2);
    ext_pin = 1'b1; cyc(2);
    chk("R3 before third edge", cnt_q, 8);
    cyc(1);
    chk("R3 at third edge", cnt_q, 9);
    pin(0);
    chk("R3 fall ignored", cnt_q, 9);

    // R5 tick ignored with external source
    tick(4);
    chk("R5 tick ignored", cnt_q, 9);

    // R4 falling edges
    cfg_edge = 1'b1; cyc(2);
    pin(1);
    chk("R4 rise ignored", cnt_q, 9);
    pin(0);
    chk("R4 fall counted", cnt_q, 10);

    // R10 select changes at steady level
    cfg_edge = 0; cyc(2); cfg_src = 0; cyc(2); cfg_src = 1; cyc(2); cfg_edge = 1; cyc(2);
    chk("R10 low level", cnt_q, 10);
    cfg_src = 0; cyc(1); pin(1); cfg_src = 1; cyc(2); cfg_edge = 0; cyc(2);
    cfg_edge = 1; cyc(2); cfg_src = 0; cyc(2);
    chk("R10 high level", cnt_q, 10);
    pin(0);

    // R6 prescaler divide by 8 and by 2
    cfg_pre_en = 1; cfg_pre_sel = 3'd2; wr(8'd0);
    tick(7);
    chk("R6 div8 partial", cnt_q, 0);
    tick(1);
    chk("R6 div8 full", cnt_q, 1);
    cfg_pre_sel = 3'd0; wr(8'd0);
    tick(6);
    chk("R6 div2", cnt_q, 3);

    // R7 write restarts prescaler
    cfg_pre_sel = 3'd3; wr(8'd0);
    tick(10);
    wr(8'h40);
    tick(15);
    chk("R7 restart partial", cnt_q, 8'h40);
    tick(1);
    chk("R7 restart full", cnt_q, 8'h41);
    cfg_pre_en = 0;
    bus_wdata = 8'h20; bus_wr = 1; tick_int = 1; cyc(1);
    bus_wr = 0; tick_int = 0; cyc(1);
    chk("R7 write beats tick", cnt_q, 8'h20);

    // R8 overflow flag
    wr(8'hFE); tick(1);
    chk("R8 no flag at FF", ovf_flag, 0);
    tick(1);
    chk("R8 wrap value", cnt_q, 0);
    chk("R8 flag set", ovf_flag, 1);
    tick(3);
    chk("R8 flag sticky", ovf_flag, 1);

    // R9 interrupt masking
    chk("R9 masked", irq, 0);
    cfg_irq_en = 1; cyc(1);
    chk("R9 enabled", irq, 1);
    clr_flag(); cyc(1);
    chk("R8 flag cleared", ovf_flag, 0);
    chk("R9 irq follows", irq, 0);
    wr(8'hFF);
    tick_int = 1; flag_clr = 1; cyc(1);
    tick_int = 0; flag_clr = 0; cyc(1);
    chk("R8 set beats clear", ovf_flag, 1);
    cfg_irq_en = 0;

    // R6 R8 random runs
    for (int r = 0; r < 20; r++) begin
      int  sel   = $urandom_range(0, 7);
      bit  pre   = 1'($urandom_range(0, 1));
      int  start = $urandom_range(0, 255);
      int  ev    = $urandom_range(0, 600);
      int  incs;
      cfg_pre_sel = 3'(sel); cfg_pre_en = pre;
      wr(8'(start)); clr_flag();
      tick(ev);
      incs = exp_incs(ev, pre, sel);
      base = start + incs;
      chk("R6 random count", cnt_q, base % 256);
      chk("R8 random flag", ovf_flag, (base > 255) ? 1 : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule